// File: doc/BRIEF.md
# Elapsed Tick Counter with Alarm Match

This block keeps a 48-bit count of slow-clock ticks. A qualifying enable arrives at 32768 per second, so bit 15 of the count is the least significant bit of whole seconds. The upper 33 bits therefore hold up to 2^33 - 1 seconds. Software reaches the count through a small register bus made of 16-bit words. The count spans three adjacent words, and a 48-bit alarm value uses the same split a few words higher. Software may load either value one word at a time.

When a tick moves the count onto the alarm value, a sticky status flag is set. Software clears the flag by writing 1 to it. The interrupt line is the flag gated by an enable bit. Reads are combinational and have no side effects. The three counter words are separate reads, so a tick can land between them. Software gets a coherent value by reading all three words twice and comparing the two passes.

Top module: `elapsedAlarm`

## Requirements
- R1: After reset, every counter word, every alarm word, the status flag and the enable bit read as 0, and irqOut is low.
- R2: Each clock with tickEn high and no counter-word write adds one to the 48-bit count, wrapping from all ones to zero. Without tickEn the count holds.
- R3: Counter word k (k = 0, 1, 2) is at byte offset 2k and holds count bits [16k+15:16k]. Carries cross word boundaries, and whole seconds equal hi<<17 | mid<<1 | lo>>15.
- R4: A write to one counter word replaces only that word. It wins over a tick in the same cycle, and the next tick continues from the written value.
- R5: Alarm word k is at byte offset 8 + 2k with the same bit layout, and it reads back what was written.
- R6: The status flag (offset 0x10, bit 0) is set by a tick whose incremented count equals all 48 alarm bits. A counter write that makes the count equal to the alarm does not set it.
- R7: Once set, the flag stays set while ticks move the count past the alarm.
- R8: A write to offset 0x10 with bit 0 = 1 clears the flag. A write with bit 0 = 0 leaves it. A set in the same cycle as a clear wins.
- R9: irqOut equals the flag ANDed with the enable bit (offset 0x12, bit 0, readable).
- R10: Address bit 0 is ignored. Unmapped word offsets (0x06, 0x0E, 0x14 and up) read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle tick qualifier, 32768 per second |
| busWrEn | input | 1 | Write strobe |
| busAddr | input | 5 | Byte address, bit 0 ignored |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Combinational read data for busAddr |
| irqOut | output | 1 | Alarm interrupt, flag AND enable |

## Verification
The match is tried with several start and alarm pairs. Some place the alarm inside the tick window and some just beyond it. One has the alarm behind the start, one needs a carry from the low word into the middle word, one needs a carry into the high word, one wraps from all ones to zero, and one crosses the seconds bit. These cases separate a compare on the full 48 bits from a compare on a single word, and a flag raised on a tick from one raised on a load. Directed cases then cover collisions in one cycle: a write against a tick, and a clear against a set.

// File: rtl/elapsedAlarmPkg.sv
package elapsedAlarmPkg;
  localparam int WORD_W    = 16;
  localparam int NUM_WORDS = 3;
  localparam int CNT_W     = WORD_W * NUM_WORDS;
  localparam int ADDR_W    = 5;
  localparam int IDX_W     = ADDR_W - 1;

  typedef struct packed {
    logic [NUM_WORDS-1:0] cntWr;
    logic [NUM_WORDS-1:0] cmpWr;
    logic                 clrFlag;
    logic                 enWr;
    logic [WORD_W-1:0]    data;
  } strobeT;
endpackage

// File: rtl/elapsedRegCtrl.sv
module elapsedRegCtrl
  import elapsedAlarmPkg::*;
#(
  parameter int CMP_IDX  = 4,
  parameter int STAT_IDX = 8,
  parameter int EN_IDX   = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  cmpVal,
  input  logic              flag,
  input  logic              irqEn,
  output strobeT            strobes,
  output logic [WORD_W-1:0] rdData
);
  logic [IDX_W-1:0]     wordIdx;
  logic [NUM_WORDS-1:0] cntHit;
  logic [NUM_WORDS-1:0] cmpHit;
  logic                 statHit;
  logic                 enHit;
  logic                 mapped;

  assign wordIdx = addr[ADDR_W-1:1];
  assign statHit = (wordIdx == IDX_W'(STAT_IDX));
  assign enHit   = (wordIdx == IDX_W'(EN_IDX));

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_dec
    assign cntHit[i] = (wordIdx == IDX_W'(i));
    assign cmpHit[i] = (wordIdx == IDX_W'(CMP_IDX + i));
  end

  assign mapped = (|cntHit) | (|cmpHit) | statHit | enHit;

  always_comb begin
    strobes.cntWr   = cntHit & {NUM_WORDS{wrEn}};
    strobes.cmpWr   = cmpHit & {NUM_WORDS{wrEn}};
    strobes.clrFlag = wrEn & statHit & wrData[0];
    strobes.enWr    = wrEn & enHit;
    strobes.data    = wrData;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (cntHit[i]) rdData = cntVal[i*WORD_W +: WORD_W];
      if (cmpHit[i]) rdData = cmpVal[i*WORD_W +: WORD_W];
    end
    if (statHit) rdData = {{(WORD_W-1){1'b0}}, flag};
    if (enHit)   rdData = {{(WORD_W-1){1'b0}}, irqEn};
  end

  // R10: a write to an unmapped word leaves the alarm and the enable untouched
  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !mapped) |=> ($stable(cmpVal) && $stable(irqEn)));
endmodule

// File: rtl/elapsedTickPath.sv
module elapsedTickPath
  import elapsedAlarmPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  strobeT           strobes,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] cmpVal,
  output logic             flag,
  output logic             irqEn
);
  logic             anyCntWr;
  logic [CNT_W-1:0] incVal;
  logic [CNT_W-1:0] cntNext;
  logic             tickHit;

  assign anyCntWr = |strobes.cntWr;
  assign incVal   = cntVal + CNT_W'(1);
  assign tickHit  = tickEn && !anyCntWr && (incVal == cmpVal);

  always_comb begin
    cntNext = cntVal;
    if (anyCntWr) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        if (strobes.cntWr[i]) cntNext[i*WORD_W +: WORD_W] = strobes.data;
      end
    end else if (tickEn) begin
      cntNext = incVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntVal <= '0;
    else       cntVal <= cntNext;
  end

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rstN)                cmpVal[i*WORD_W +: WORD_W] <= '0;
      else if (strobes.cmpWr[i]) cmpVal[i*WORD_W +: WORD_W] <= strobes.data;
    end

    // R4: a written counter word holds the written data on the next cycle
    a_r4_word_write: assert property (@(posedge clk) disable iff (!rstN)
      strobes.cntWr[i] |=> (cntVal[i*WORD_W +: WORD_W] == $past(strobes.data)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag  <= 1'b0;
      irqEn <= 1'b0;
    end else begin
      if (tickHit)              flag <= 1'b1;
      else if (strobes.clrFlag) flag <= 1'b0;
      if (strobes.enWr)         irqEn <= strobes.data[0];
    end
  end

  // R2: without a tick or a write the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !anyCntWr) |=> $stable(cntVal));
  // R2: a tick without a write advances by exactly one
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !anyCntWr) |=> (cntVal == $past(cntVal) + CNT_W'(1)));
  // R6: the flag only rises after a tick
  a_r6_set_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(tickEn));
  // R7: the flag stays set until cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !strobes.clrFlag) |=> flag);
  // R8: a clear with no simultaneous match drops the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    (flag && strobes.clrFlag && !tickHit) |=> !flag);
endmodule

// File: rtl/elapsedAlarm.sv
module elapsedAlarm
  import elapsedAlarmPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  output logic              irqOut
);
  strobeT           strobes;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] cmpVal;
  logic             flag;
  logic             irqEn;

  elapsedRegCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (busWrEn),
    .addr    (busAddr),
    .wrData  (busWrData),
    .cntVal  (cntVal),
    .cmpVal  (cmpVal),
    .flag    (flag),
    .irqEn   (irqEn),
    .strobes (strobes),
    .rdData  (busRdData)
  );

  elapsedTickPath i_path (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .strobes (strobes),
    .cntVal  (cntVal),
    .cmpVal  (cmpVal),
    .flag    (flag),
    .irqEn   (irqEn)
  );

  assign irqOut = flag & irqEn;
endmodule

// File: tb/test_elapsedAlarm.sv
module test_elapsedAlarm;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC    = 7;
  localparam logic [47:0] MASK48 = 48'hFFFF_FFFF_FFFF;
  // {start, alarm, ticks}
  localparam logic [111:0] VEC [NUM_VEC] = '{
    {48'h0000_0000_0000, 48'h0000_0000_0005, 16'd5},
    {48'h0000_0000_0000, 48'h0000_0000_0006, 16'd5},
    {48'h0000_0000_FFFF, 48'h0000_0001_0001, 16'd2},
    {48'h0000_FFFF_FFFF, 48'h0000_0000_0000, 16'd3},
    {48'hFFFF_FFFF_FFFF, 48'h0000_0000_0000, 16'd1},
    {48'h0000_0000_7FFE, 48'h0000_0000_8000, 16'd2},
    {48'h0000_0000_000A, 48'h0000_0000_0003, 16'd4}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busWrEn = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        irqOut;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  elapsedAlarm i_elapsedAlarm (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); busAddr = a; #1; d = busRdData;
  endtask

  task automatic rd48(input logic [4:0] base, output logic [47:0] v);
    logic [15:0] w;
    for (int k = 0; k < 3; k++) begin
      rd(base + 5'(2*k), w);
      v[16*k +: 16] = w;
    end
  endtask

  task automatic wr48(input logic [4:0] base, input logic [47:0] v);
    for (int k = 0; k < 3; k++) wr(base + 5'(2*k), v[16*k +: 16]);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] v48, start, alarm, expCnt;
    logic [15:0] w;
    logic        expFlag;
    int          n;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rd48(5'h00, v48); check("R1 counter", v48, 0);
    rd48(5'h08, v48); check("R1 alarm", v48, 0);
    rd(5'h10, w); check("R1 flag", w, 0);
    rd(5'h12, w); check("R1 enable", w, 0);
    check("R1 irqOut", irqOut, 0);

    // Vector table: R2 R3 R5 R6
    for (int i = 0; i < NUM_VEC; i++) begin
      start = VEC[i][111:64];
      alarm = VEC[i][63:16];
      n     = int'(VEC[i][15:0]);
      wr48(5'h00, start);
      wr48(5'h08, alarm);
      wr(5'h10, 16'h0001);
      expFlag = 1'b0;
      for (int k = 1; k <= n; k++)
        if (((start + 48'(k)) & MASK48) == alarm) expFlag = 1'b1;
      expCnt = (start + 48'(n)) & MASK48;
      ticks(n);
      rd48(5'h00, v48); check("R2 R3 counter after ticks", v48, expCnt);
      rd48(5'h08, v48); check("R5 alarm readback", v48, alarm);
      rd(5'h10, w); check("R6 flag after ticks", w, {15'b0, expFlag});
    end

    // R3: seconds bit (last vector before this reloads; recheck with 0x7FFF)
    wr48(5'h00, 48'h0000_0002_7FFF);
    ticks(1);
    rd48(5'h00, v48);
    check("R3 seconds", {v48[47:32], 17'b0} | {v48[31:16], 1'b0} | 64'(v48[15:15]), 64'h5);

    // R4: partial write
    wr48(5'h00, 48'h0003_0002_0001);
    wr(5'h02, 16'hABCD);
    rd48(5'h00, v48); check("R4 mid write only", v48, 48'h0003_ABCD_0001);
    @(negedge clk); busWrEn = 1'b1; busAddr = 5'h00; busWrData = 16'h1234; tickEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0; tickEn = 1'b0;
    rd48(5'h00, v48); check("R4 write beats tick", v48, 48'h0003_ABCD_1234);
    ticks(1);
    rd48(5'h00, v48); check("R4 resume from written", v48, 48'h0003_ABCD_1235);

    // R6: write that equals the alarm does not set
    wr(5'h10, 16'h0001);
    wr48(5'h08, 48'h0000_0000_0100);
    wr48(5'h00, 48'h0000_0000_0100);
    rd(5'h10, w); check("R6 no set on load", w, 0);

    // R7 R8 R9
    wr48(5'h00, 48'h0000_0000_00FF);
    ticks(1);
    rd(5'h10, w); check("R6 set on tick", w, 1);
    check("R9 irq masked", irqOut, 0);
    ticks(3);
    rd(5'h10, w); check("R7 sticky", w, 1);
    wr(5'h10, 16'hFFFE);
    rd(5'h10, w); check("R8 write0 keeps", w, 1);
    wr(5'h12, 16'h0001);
    rd(5'h12, w); check("R9 enable readback", w, 1);
    check("R9 irq asserted", irqOut, 1);
    wr(5'h10, 16'h0001);
    rd(5'h10, w); check("R8 w1c clears", w, 0);
    check("R9 irq drops", irqOut, 0);

    // R8: set wins over clear
    wr48(5'h00, 48'h0000_0000_00FF);
    @(negedge clk); busWrEn = 1'b1; busAddr = 5'h10; busWrData = 16'h0001; tickEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0; tickEn = 1'b0;
    rd(5'h10, w); check("R8 set beats clear", w, 1);

    // R10: unmapped and odd addresses
    wr48(5'h00, 48'h0000_0000_0000);
    wr(5'h06, 16'hFFFF); wr(5'h0E, 16'hFFFF); wr(5'h14, 16'hFFFF);
    rd(5'h06, w); check("R10 read 0x06", w, 0);
    rd(5'h14, w); check("R10 read 0x14", w, 0);
    rd48(5'h00, v48); check("R10 counter untouched", v48, 0);
    rd48(5'h08, v48); check("R10 alarm untouched", v48, 48'h0000_0000_0100);
    wr(5'h09, 16'h5555);
    rd(5'h08, w); check("R10 bit0 ignored", w, 16'h5555);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule